// File: doc/BRIEF.md
# Dual-Lane Hit Frame Serializer

This block turns the hit summary of one bunch crossing into two serial bit streams. The encoder upstream runs on a slow bunch-crossing clock. Once per slow period it presents a shared parity bit and two hit words. Each hit word is a valid flag and a 6-bit Gray-coded cell address. The serializer runs on a fast clock at eight times the slow rate, and the slow clock is derived from it. It samples the slow clock as an ordinary signal through a short synchronizer. It aligns a 3-bit phase counter to the detected rising edge. Then, in one fixed phase, it loads an 8-bit frame into each lane's shift register.

Each lane sends its frame MSB first, one bit per fast cycle. The first slot carries the shared parity, the second that lane's hit flag, and the remaining six the address from bit 5 down to bit 0. A new frame follows the previous one with no idle slot. Until the first slow rising edge has been seen, both lanes stay low.

Top module: `hit_frame_serializer`

## Requirements
- R1: After a synchronous reset, both lane outputs are 0.
- R2: Before the first rising edge of `slow_clk` is detected, both lanes stay 0, whatever the data inputs do.
- R3: Lane 1 sends, one bit per fast cycle, `parity_in`, then `hit1_in`, then `addr1_in[5]` down to `addr1_in[0]`.
- R4: Lane 2 sends, one bit per fast cycle, `parity_in`, then `hit2_in`, then `addr2_in[5]` down to `addr2_in[0]`.
- R5: The first slot of both lanes carries the same parity value in the same cycle.
- R6: Fast edge 0 is the first fast rising edge that samples `slow_clk` high. The first frame bit is driven from fast edge 6, and each later bit is driven one edge later.
- R7: A frame holds the data inputs present at the fast edge that loads it. Input changes after that edge do not alter the frame being sent.
- R8: With `slow_clk` running at one eighth of the fast rate, frames follow each other back to back, 8 bits per slow period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast serial clock (8x slow clock) |
| rst | input | 1 | Synchronous active-high reset |
| slow_clk | input | 1 | Bunch-crossing clock, sampled as data |
| parity_in | input | 1 | Global hit parity for the crossing |
| hit1_in | input | 1 | Hit flag for lane 1 |
| addr1_in | input | 6 | Gray-coded cell address for lane 1 |
| hit2_in | input | 1 | Hit flag for lane 2 |
| addr2_in | input | 6 | Gray-coded cell address for lane 2 |
| lane1_out | output | 1 | Serial frame output, lane 1 |
| lane2_out | output | 1 | Serial frame output, lane 2 |

## Verification
The embedded properties check several things on every cycle. The edge pulse is a single cycle wide. Each shift step moves the next lower bit to the output. Parity and the lane-2 hit flag appear in their slots one and two cycles after each load. Both lanes stay silent before alignment. Only the bench scenarios show the absolute six-cycle latency from the slow edge and the full slot order of the addresses. They also show that inputs scrambled after the load edge are ignored, and that frames run without gaps over long random streams.

// File: rtl/hfs_pkg.sv
package hfs_pkg;
  parameter int ADDR_W = 6;
  localparam int FRAME_W = ADDR_W + 2;

  typedef struct packed {
    logic              hit;
    logic [ADDR_W-1:0] addr;
  } lane_word_t;
endpackage

// File: rtl/hfs_edge_sync.sv
module hfs_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], async_in};
      last_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign rise_o = sync_q[SYNC_STAGES-1] & ~last_q;

  // R6: a detected edge is a single-cycle pulse
  p_rise_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    rise_o |=> !rise_o);
endmodule

// File: rtl/hfs_phase_ctr.sv
module hfs_phase_ctr #(
  parameter int RATIO      = 8,
  parameter int LOAD_PHASE = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic rise_i,
  output logic load_o,
  output logic aligned_o
);
  localparam int CNT_W = $clog2(RATIO);

  logic [CNT_W-1:0] cnt_q;
  logic             aligned_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q     <= '0;
      aligned_q <= 1'b0;
    end else begin
      if (rise_i)
        cnt_q <= '0;
      else if (cnt_q == CNT_W'(RATIO - 1))
        cnt_q <= '0;
      else
        cnt_q <= cnt_q + 1'b1;
      if (rise_i)
        aligned_q <= 1'b1;
    end
  end

  assign load_o    = aligned_q && (cnt_q == CNT_W'(LOAD_PHASE));
  assign aligned_o = aligned_q;

  // R8: loads come no closer than once per ratio period unless realigned
  p_load_gap_r8: assert property (@(posedge clk) disable iff (rst)
    load_o |=> !load_o);
endmodule

// File: rtl/hfs_lane_shift.sv
module hfs_lane_shift #(
  parameter int FRAME_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load_i,
  input  logic [FRAME_W-1:0] frame_i,
  output logic               ser_o
);
  logic [FRAME_W-1:0] sreg_q;

  always_ff @(posedge clk) begin
    if (rst)
      sreg_q <= '0;
    else if (load_i)
      sreg_q <= frame_i;
    else
      sreg_q <= {sreg_q[FRAME_W-2:0], 1'b0};
  end

  assign ser_o = sreg_q[FRAME_W-1];

  // R3: each shift step presents the next lower frame bit
  p_shift_order_r3: assert property (@(posedge clk) disable iff (rst)
    !load_i |=> ser_o == $past(sreg_q[FRAME_W-2]));
endmodule

// File: rtl/hit_frame_serializer.sv
module hit_frame_serializer
  import hfs_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RATIO       = 8,
  parameter int LOAD_PHASE  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              slow_clk,
  input  logic              parity_in,
  input  logic              hit1_in,
  input  logic [ADDR_W-1:0] addr1_in,
  input  logic              hit2_in,
  input  logic [ADDR_W-1:0] addr2_in,
  output logic              lane1_out,
  output logic              lane2_out
);
  localparam int NUM_LANES = 2;

  logic       rise;
  logic       load;
  logic       aligned;
  lane_word_t words [NUM_LANES];
  logic       ser   [NUM_LANES];

  hfs_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_in(slow_clk), .rise_o(rise)
  );

  hfs_phase_ctr #(.RATIO(RATIO), .LOAD_PHASE(LOAD_PHASE)) u_ctr (
    .clk(clk), .rst(rst), .rise_i(rise), .load_o(load), .aligned_o(aligned)
  );

  assign words[0] = '{hit: hit1_in, addr: addr1_in};
  assign words[1] = '{hit: hit2_in, addr: addr2_in};

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    hfs_lane_shift #(.FRAME_W(FRAME_W)) u_shift (
      .clk(clk), .rst(rst), .load_i(load),
      .frame_i({parity_in, words[g]}), .ser_o(ser[g])
    );
  end

  assign lane1_out = ser[0];
  assign lane2_out = ser[1];

  // R2: lanes silent until the slow clock has been seen
  p_idle_zero_r2: assert property (@(posedge clk) disable iff (rst)
    !aligned |-> (!lane1_out && !lane2_out));

  // R5: both lanes open the frame with the captured parity
  p_slot0_parity_r5: assert property (@(posedge clk) disable iff (rst)
    load |=> (lane1_out == $past(parity_in)) && (lane2_out == $past(parity_in)));

  // R4: lane 2 second slot is its hit flag
  p_slot1_hit_r4: assert property (@(posedge clk) disable iff (rst)
    load |=> ##1 (lane2_out == $past(hit2_in, 2)));
endmodule

// File: tb/hit_frame_serializer_tb_top.sv
module hit_frame_serializer_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       slow_clk = 1'b0;
  logic       parity_in = 1'b0;
  logic       hit1_in = 1'b0;
  logic [5:0] addr1_in = '0;
  logic       hit2_in = 1'b0;
  logic [5:0] addr2_in = '0;
  logic       lane1_out, lane2_out;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [7:0] f1_q [0:63];
  logic [7:0] f2_q [0:63];

  always #2 clk = ~clk;

  hit_frame_serializer dut_i (
    .clk(clk), .rst(rst), .slow_clk(slow_clk), .parity_in(parity_in),
    .hit1_in(hit1_in), .addr1_in(addr1_in), .hit2_in(hit2_in),
    .addr2_in(addr2_in), .lane1_out(lane1_out), .lane2_out(lane2_out)
  );

  function automatic logic [7:0] mk_frame(logic p, logic h, logic [5:0] a);
    return {p, h, a};
  endfunction

  task automatic check_bit(logic act, logic exp, string req);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic scramble();
    parity_in = 1'($urandom); hit1_in = 1'($urandom); hit2_in = 1'($urandom);
    addr1_in = 6'($urandom); addr2_in = 6'($urandom);
  endtask

  task automatic do_reset();
    rst = 1'b1; slow_clk = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_bit(lane1_out, 1'b0, "R1 lane1");
    check_bit(lane2_out, 1'b0, "R1 lane2");
    // R2: data activity with no slow edge
    for (int i = 0; i < 20; i++) begin
      scramble();
      @(negedge clk);
      check_bit(lane1_out, 1'b0, "R2 lane1");
      check_bit(lane2_out, 1'b0, "R2 lane2");
    end
  endtask

  task automatic set_directed(int j);
    case (j)
      0: begin parity_in=0; hit1_in=0; addr1_in=6'b000000; hit2_in=0; addr2_in=6'b000000; end
      1: begin parity_in=1; hit1_in=1; addr1_in=6'b111111; hit2_in=1; addr2_in=6'b111111; end
      2: begin parity_in=1; hit1_in=1; addr1_in=6'b101010; hit2_in=0; addr2_in=6'b000000; end
      3: begin parity_in=0; hit1_in=1; addr1_in=6'b000001; hit2_in=1; addr2_in=6'b100000; end
      4: begin parity_in=1; hit1_in=0; addr1_in=6'b000000; hit2_in=0; addr2_in=6'b000000; end
      default: begin parity_in=0; hit1_in=0; addr1_in=6'b111110; hit2_in=1; addr2_in=6'b010101; end
    endcase
  endtask

  task automatic run_stream(int nframes, bit directed);
    for (int m = 0; m < nframes*8 + 7; m++) begin
      @(negedge clk);
      if (m >= 7) begin
        int j = (m - 7) / 8;
        int b = (m - 7) % 8;
        string r1 = (b == 0) ? ((j == 0) ? "R6 R5 lane1" : "R5 lane1") : "R3 R7 R8 lane1";
        string r2 = (b == 0) ? ((j == 0) ? "R6 R5 lane2" : "R5 lane2") : "R4 R7 R8 lane2";
        check_bit(lane1_out, f1_q[j][7-b], r1);
        check_bit(lane2_out, f2_q[j][7-b], r2);
      end else begin
        check_bit(lane1_out, 1'b0, "R6 early lane1");
        check_bit(lane2_out, 1'b0, "R6 early lane2");
      end
      if (m % 8 == 0 && m / 8 < nframes) begin
        slow_clk = 1'b1;
        if (directed) set_directed(m / 8);
        else scramble();
        f1_q[m/8] = mk_frame(parity_in, hit1_in, addr1_in);
        f2_q[m/8] = mk_frame(parity_in, hit2_in, addr2_in);
      end else if (m % 8 == 4) begin
        slow_clk = 1'b0;
      end else if (m % 8 == 7) begin
        scramble();  // R7: change after the load edge must not leak
      end
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    do_reset();
    run_stream(6, 1'b1);
    do_reset();
    run_stream(60, 1'b0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule